// File: doc/BRIEF.md
# Condition Register Field Compare Updater

This block performs an integer compare of two 32-bit operands and deposits the outcome as a 4-bit code into one chosen field of a 32-bit condition register. The compare is either two's complement or plain magnitude, chosen per operation. The second operand is either a register value or a 16-bit immediate, which is widened according to the compare kind.

The code holds four flags: less-than, greater-than, equal, and a copy of the incoming summary-overflow flag. The condition register holds eight such fields. Field n covers register bits 4n to 4n+3, counted from the most significant end. The operation reads the current register value on an input port. It changes only the chosen field and returns the new register value one clock later. Decoding the operation is done elsewhere.

Top module: `crf_cmp_update`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `cr_out` is all zeros and `out_valid` is 0.
- R2: When `in_valid` is high at a rising edge, `out_valid` is high and `cr_out` carries the result after that edge. In every other cycle `out_valid` is 0.
- R3: With `is_signed`=1 the operands are compared as two's complement numbers. For example, 0x7FFFFFFF compared against 0x80000000 gives greater-than.
- R4: With `is_signed`=0 the operands are compared as unsigned magnitudes. For example, 0x7FFFFFFF compared against 0x80000000 gives less-than.
- R5: With `use_imm`=1 the second operand is `imm` rather than `opb`. For a signed compare `imm` is sign-extended from bit 15. For an unsigned compare it is zero-extended.
- R6: After every compare, exactly one of the less-than, greater-than and equal flags in the written field is 1.
- R7: The summary-overflow position of the written field equals the `sum_ovf` input of that operation.
- R8: The field chosen by `dst_field`=n occupies `cr_out[31-4n:28-4n]`. In that slice, bit 31-4n is less-than, 30-4n is greater-than, 29-4n is equal and 28-4n is summary-overflow.
- R9: All bits of `cr_out` outside the chosen field equal the corresponding bits of `cr_in` sampled with the operation.
- R10: In a cycle that follows an edge with `in_valid` low, `cr_out` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand (register form) |
| imm | input | 16 | Second operand (immediate form) |
| use_imm | input | 1 | 1 selects `imm` as second operand |
| is_signed | input | 1 | 1 selects a two's complement compare |
| dst_field | input | 3 | Destination field index 0..7 |
| sum_ovf | input | 1 | Summary-overflow flag to copy |
| cr_in | input | 32 | Current condition register value |
| out_valid | output | 1 | `cr_out` holds a fresh result |
| cr_out | output | 32 | Updated condition register |

## Verification
The clocked properties assume that `in_valid`, `dst_field`, `cr_in` and `sum_ovf` are known, two-valued levels at each rising edge after reset. The unknown-value guard on the one-hot check covers only the time before the operands are first driven. The stimulus drives every input at a fixed offset after the rising edge. It keeps `in_valid` low throughout reset, so every `$past` term after reset release refers to defined values. Idle cycles are mixed with operations, and those idle cycles carry changing operands, so the hold property is exercised under moving inputs.

// File: rtl/crf_pkg.sv
package crf_pkg;

    localparam int FIELD_W = 4;

    // Flag order inside a field, most significant first
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } crf_code_t;

    // Mask of one field inside a register of nfields fields, MSB-first numbering
    function automatic logic [31:0] field_mask(input int unsigned idx);
        logic [31:0] m;
        m = '0;
        for (int k = 0; k < FIELD_W; k++) begin
            m[31 - FIELD_W * idx - k] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/crf_opnd_sel.sv
module crf_opnd_sel #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] reg_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    input  logic              is_signed,
    output logic [DATA_W-1:0] b_eff
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic              ext_bit;
    logic [DATA_W-1:0] imm_wide;

    always_comb begin
        ext_bit  = is_signed & imm[IMM_W-1];
        imm_wide = {{EXT_W{ext_bit}}, imm};
        b_eff    = use_imm ? imm_wide : reg_b;
    end
endmodule

// File: rtl/crf_magcmp.sv
module crf_magcmp #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              is_signed,
    output logic              lt,
    output logic              gt,
    output logic              eq
);
    logic [DATA_W-1:0] a_bias;
    logic [DATA_W-1:0] b_bias;

    // Flipping the sign bit maps two's complement order onto unsigned order
    always_comb begin
        a_bias = {a[DATA_W-1] ^ is_signed, a[DATA_W-2:0]};
        b_bias = {b[DATA_W-1] ^ is_signed, b[DATA_W-2:0]};
        eq     = (a == b);
        lt     = (a_bias < b_bias);
        gt     = !lt && !eq;
    end

    // R6: exactly one relation flag
    always_comb begin
        if (!$isunknown({a, b, is_signed})) begin
            a_r6_one_relation: assert ($onehot({lt, gt, eq}))
                else $error("R6: relation flags not one-hot");
        end
    end
endmodule

// File: rtl/crf_field_merge.sv
module crf_field_merge
    import crf_pkg::*;
#(
    parameter int FIELDS = 8,
    localparam int CR_W  = FIELDS * FIELD_W,
    localparam int IDX_W = $clog2(FIELDS)
) (
    input  logic [CR_W-1:0]  cr_in,
    input  logic [IDX_W-1:0] dst,
    input  crf_code_t        code,
    output logic [CR_W-1:0]  cr_new
);
    genvar g;
    generate
        for (g = 0; g < FIELDS; g++) begin : g_field
            localparam int HI = CR_W - 1 - FIELD_W * g;
            assign cr_new[HI -: FIELD_W] =
                (dst == IDX_W'(g)) ? code : cr_in[HI -: FIELD_W];
        end
    endgenerate
endmodule

// File: rtl/crf_cmp_update.sv
module crf_cmp_update
    import crf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int FIELDS = 8,
    localparam int CR_W  = FIELDS * FIELD_W,
    localparam int IDX_W = $clog2(FIELDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    input  logic              is_signed,
    input  logic [IDX_W-1:0]  dst_field,
    input  logic              sum_ovf,
    input  logic [CR_W-1:0]   cr_in,
    output logic              out_valid,
    output logic [CR_W-1:0]   cr_out
);
    typedef struct packed {
        logic            vld;
        logic [CR_W-1:0] cr;
    } state_t;

    state_t            st_d, st_q;
    logic [DATA_W-1:0] b_eff;
    logic              rel_lt, rel_gt, rel_eq;
    crf_code_t         code;
    logic [CR_W-1:0]   cr_merged;

    crf_opnd_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
        .reg_b(opb), .imm(imm), .use_imm(use_imm),
        .is_signed(is_signed), .b_eff(b_eff)
    );

    crf_magcmp #(.DATA_W(DATA_W)) u_cmp (
        .a(opa), .b(b_eff), .is_signed(is_signed),
        .lt(rel_lt), .gt(rel_gt), .eq(rel_eq)
    );

    always_comb begin
        code.lt = rel_lt;
        code.gt = rel_gt;
        code.eq = rel_eq;
        code.so = sum_ovf;
    end

    crf_field_merge #(.FIELDS(FIELDS)) u_merge (
        .cr_in(cr_in), .dst(dst_field), .code(code), .cr_new(cr_merged)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.cr = cr_merged;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign cr_out    = st_q.cr;

    // R2: an accepted operation yields a result on the next cycle
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9: fields other than the destination follow cr_in
    a_r9_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && $past(rst_n)) |=>
            (((cr_out ^ $past(cr_in)) & ~field_mask($past(dst_field))) == '0));

    // R7: summary-overflow copy lands in the destination field
    a_r7_so_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && $past(rst_n)) |=>
            (((cr_out & field_mask($past(dst_field)) & {FIELDS{4'b0001}}) != '0)
             == $past(sum_ovf)));

    // R10: without an operation the register output holds
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && $past(rst_n)) |=> $stable(cr_out));
endmodule

// File: tb/crf_cmp_update_test.sv
`timescale 1ns/1ps
module crf_cmp_update_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] opa = '0, opb = '0, cr_in = '0;
    logic [15:0] imm = '0;
    logic        use_imm = 1'b0, is_signed = 1'b0, sum_ovf = 1'b0;
    logic [2:0]  dst_field = '0;
    logic        out_valid;
    logic [31:0] cr_out;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    logic [31:0] exp_cr = '0;

    always #2.5 clk = ~clk;

    crf_cmp_update uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
        .imm(imm), .use_imm(use_imm), .is_signed(is_signed),
        .dst_field(dst_field), .sum_ovf(sum_ovf), .cr_in(cr_in),
        .out_valid(out_valid), .cr_out(cr_out)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Behavioural model of one operation
    function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b,
        logic [15:0] im, bit ui, bit sg, int fld, bit so, logic [31:0] cr);
        longint av, bv;
        logic [31:0] r;
        bit flags[4];
        if (ui) bv = sg ? longint'($signed(im)) : longint'(im);
        else    bv = sg ? longint'($signed(b))  : longint'(b);
        av = sg ? longint'($signed(a)) : longint'(a);
        flags[0] = av < bv;
        flags[1] = av > bv;
        flags[2] = av == bv;
        flags[3] = so;
        r = cr;
        for (int k = 0; k < 4; k++) r[31 - (4*fld + k)] = flags[k];
        return r;
    endfunction

    task automatic op(string req, bit v, logic [31:0] a, logic [31:0] b,
        logic [15:0] im, bit ui, bit sg, int fld, bit so, logic [31:0] cr);
        in_valid = v; opa = a; opb = b; imm = im; use_imm = ui;
        is_signed = sg; dst_field = fld[2:0]; sum_ovf = so; cr_in = cr;
        if (v) exp_cr = model(a, b, im, ui, sg, fld, so, cr);
        @(posedge clk); #1;
        check(req, {31'd0, out_valid}, {31'd0, v});
        check(req, cr_out, exp_cr);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", cr_out, 32'h0);
        check("R1 reset", {31'd0, out_valid}, 32'h0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 after release", cr_out, 32'h0);

        // R3 / R4 boundary pair under both interpretations
        op("R3 signed max vs min", 1, 32'h7FFFFFFF, 32'h80000000, 0, 0, 1, 0, 0, 32'h0);
        check("R3 gt set", cr_out & 32'hF0000000, 32'h40000000);
        op("R4 unsigned max vs min", 1, 32'h7FFFFFFF, 32'h80000000, 0, 0, 0, 0, 0, 32'h0);
        check("R4 lt set", cr_out & 32'hF0000000, 32'h80000000);
        op("R3 signed reversed", 1, 32'h80000000, 32'h7FFFFFFF, 0, 0, 1, 3, 1, 32'hFFFFFFFF);
        op("R4 unsigned reversed", 1, 32'h80000000, 32'h7FFFFFFF, 0, 0, 0, 5, 0, 32'h12345678);
        op("R6 equal", 1, 32'hDEADBEEF, 32'hDEADBEEF, 0, 0, 1, 2, 0, 32'hA5A5A5A5);
        op("R3 negatives", 1, 32'hFFFFFFFE, 32'hFFFFFFFF, 0, 0, 1, 6, 0, 32'h0F0F0F0F);

        // R5 immediate widening
        op("R5 signed imm -1 eq", 1, 32'hFFFFFFFF, 0, 16'hFFFF, 1, 1, 1, 0, 32'h0);
        op("R5 unsigned imm zero-ext", 1, 32'hFFFFFFFF, 0, 16'hFFFF, 1, 0, 1, 0, 32'h0);
        op("R5 imm 0x8000 signed", 1, 32'h0, 32'h7, 16'h8000, 1, 1, 4, 1, 32'h0);

        // R7 / R8 / R9: every destination field, varied background
        for (int f = 0; f < 8; f++) begin
            op("R8 field placement", 1, 32'd5 * f, 32'd10, 0, 0, f[0], f, f[1],
               32'h9E3779B9 * (f + 1));
            check("R7 so copy", {31'd0, cr_out[28 - 4*f]}, {31'd0, f[1]});
            check("R9 others kept", cr_out & ~(32'hF0000000 >> (4*f)),
                  (32'h9E3779B9 * (f + 1)) & ~(32'hF0000000 >> (4*f)));
        end

        // R10 idle cycles with moving inputs
        op("R10 hold", 0, 32'h1, 32'h2, 0, 0, 0, 7, 1, 32'hFFFFFFFF);
        op("R10 hold", 0, 32'h9, 32'h2, 16'h1, 1, 1, 0, 0, 32'h0);
        op("R2 resume", 1, 32'h1, 32'h1, 0, 0, 0, 7, 1, 32'h0);

        // Mixed sweep
        for (int i = 0; i < 40; i++) begin
            logic [31:0] a, b, c;
            a = 32'h6C078965 * (i + 3);
            b = 32'h41C64E6D * (i + 7) + (i % 3 == 0 ? a : 32'h0) - (i % 3 == 0 ? 32'h41C64E6D * (i + 7) : 32'h0);
            c = 32'h2545F491 * (i + 11);
            op("R6 sweep", i % 5 != 4, a, b, a[15:0] ^ 16'(i), i[1], i[0], i % 8, i[2], c);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule